// File: doc/BRIEF.md
# Masked-Halfword Control Register Bank

This block holds a small set of 32-bit control registers on a plain single-cycle write/read bus. A write never needs a prior read. The upper half of every write word is a per-bit enable mask for the lower half. Only the low-half bits whose enable is set take the new value. All other bits keep what they held.

Two of the registers drive named control fields straight onto output ports:
- a lane control word with four 4-bit fields;
- a test-access word carrying an 8-bit data byte and three single-bit strobes.

A read-only status location returns an 8-bit value taken from an input port. Reads are combinational from the address. Writes take effect on the rising clock edge.

Top module: `ctl_bank_top`

## Requirements
- R1: On a write to a control register, every bit i in [15:0] whose enable bit i+16 of the write word is 1 takes bit i of the write word after the clock edge.
- R2: On a write to a control register, every bit i in [15:0] whose enable bit i+16 is 0 keeps its previous value.
- R3: A read of a control register returns its stored 16-bit value in [15:0] and zero in [31:16].
- R4: A read at offset 0xE2A4 returns the `stat_byte` input in [7:0] and zero in [31:8].
- R5: A write to 0xE2A4 or to any offset that is not a control register changes no stored bit.
- R6: A synchronous active-high reset clears every control register to zero.
- R7: The register at 0x6254 drives four 4-bit fields: `lane_on` from bits [3:0], `lane_force_rx` from [7:4], `lane_force_stop` from [11:8] and `lane_turn_off` from [15:12].
- R8: The register at 0x6264 drives `tst_din` from bits [7:0], `tst_en` from bit 8, `tst_clk` from bit 9 and `tst_clr` from bit 10.
- R9: A read at an offset that is neither a control register nor 0xE2A4 returns zero.
- R10: A write changes only the addressed register. The control registers sit at offsets 0x6224, 0x6254, 0x6258, 0x625C, 0x6260 and 0x6264.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Byte offset for read and write |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write word: enable mask in [31:16], value in [15:0] |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| stat_byte | input | 8 | Value returned by the status location |
| lane_on | output | 4 | Lane enable field |
| lane_force_rx | output | 4 | Force-receive field |
| lane_force_stop | output | 4 | Force-stop-state field |
| lane_turn_off | output | 4 | Turnaround-disable field |
| tst_din | output | 8 | Test data byte |
| tst_en | output | 1 | Test enable strobe |
| tst_clk | output | 1 | Test clock level |
| tst_clr | output | 1 | Test clear level |

## Verification
A wrong merge, whether unmasked bits are overwritten or masked bits are dropped, shows up one cycle after the write. It is visible on the read data of that register. For the two field-driving registers it is also visible directly on the output pins.

A decoder fault damages a neighbouring register, or lets status and unmapped writes through. This stays hidden until that register is read back. The bench therefore sweeps every register periodically during random traffic, so such a fault is reported within a few dozen operations.

// File: rtl/ctl_bank_pkg.sv
package ctl_bank_pkg;
  localparam int HALF_W   = 16;
  localparam int WORD_W   = 2 * HALF_W;
  localparam int ADDR_W   = 16;
  localparam int NUM_CTL  = 6;
  localparam int LANE_IDX = 1;
  localparam int TST_IDX  = 5;

  localparam logic [NUM_CTL-1:0][ADDR_W-1:0] CTL_OFFS = {
    16'h6264, 16'h6260, 16'h625c, 16'h6258, 16'h6254, 16'h6224
  };
  localparam logic [ADDR_W-1:0] STAT_OFF = 16'he2a4;

  // new = old where mask bit clear, data where mask bit set
  function automatic logic [HALF_W-1:0] merge_half(
    input logic [HALF_W-1:0] old_q,
    input logic [WORD_W-1:0] word
  );
    logic [HALF_W-1:0] en;
    en = word[WORD_W-1:HALF_W];
    return (old_q & ~en) | (word[HALF_W-1:0] & en);
  endfunction
endpackage

// File: rtl/ctl_addr_dec.sv
module ctl_addr_dec
  import ctl_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_CTL-1:0] ctl_hit,
  output logic              stat_hit
);
  for (genvar i = 0; i < NUM_CTL; i++) begin : g_hit
    assign ctl_hit[i] = (addr == CTL_OFFS[i]);
  end
  assign stat_hit = (addr == STAT_OFF);

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl_hit, stat_hit})); // R10
endmodule

// File: rtl/ctl_mreg.sv
module ctl_mreg
  import ctl_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit,
  input  logic [WORD_W-1:0] wword,
  output logic [HALF_W-1:0] q
);
  logic [HALF_W-1:0] en_bits;
  assign en_bits = wword[WORD_W-1:HALF_W];

  always_ff @(posedge clk) begin
    if (rst)         q <= '0;
    else if (wr_hit) q <= merge_half(q, wword);
  end

  AST_MASKED_SET: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> ((q & $past(en_bits)) == ($past(wword[HALF_W-1:0]) & $past(en_bits)))); // R1
  AST_UNMASKED_HOLD: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> (((q ^ $past(q)) & ~$past(en_bits)) == '0)); // R2
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> $stable(q)); // R5
endmodule

// File: rtl/ctl_bank_top.sv
module ctl_bank_top
  import ctl_bank_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [7:0]  stat_byte,
  output logic [3:0]  lane_on,
  output logic [3:0]  lane_force_rx,
  output logic [3:0]  lane_force_stop,
  output logic [3:0]  lane_turn_off,
  output logic [7:0]  tst_din,
  output logic        tst_en,
  output logic        tst_clk,
  output logic        tst_clr
);
  logic [NUM_CTL-1:0]             ctl_hit;
  logic                           stat_hit;
  logic [NUM_CTL-1:0][HALF_W-1:0] regs;
  logic [HALF_W-1:0]              rd_half;

  ctl_addr_dec u_dec (
    .clk      (clk),
    .rst      (rst),
    .addr     (bus_addr),
    .ctl_hit  (ctl_hit),
    .stat_hit (stat_hit)
  );

  for (genvar i = 0; i < NUM_CTL; i++) begin : g_reg
    ctl_mreg u_reg (
      .clk    (clk),
      .rst    (rst),
      .wr_hit (bus_wr && ctl_hit[i]),
      .wword  (bus_wdata),
      .q      (regs[i])
    );
  end

  always_comb begin
    rd_half = '0;
    for (int i = 0; i < NUM_CTL; i++)
      if (ctl_hit[i]) rd_half = rd_half | regs[i];
    if (stat_hit) rd_half = rd_half | {{(HALF_W-8){1'b0}}, stat_byte};
  end
  assign bus_rdata = {{HALF_W{1'b0}}, rd_half};

  assign lane_on         = regs[LANE_IDX][3:0];
  assign lane_force_rx   = regs[LANE_IDX][7:4];
  assign lane_force_stop = regs[LANE_IDX][11:8];
  assign lane_turn_off   = regs[LANE_IDX][15:12];
  assign tst_din         = regs[TST_IDX][7:0];
  assign tst_en          = regs[TST_IDX][8];
  assign tst_clk         = regs[TST_IDX][9];
  assign tst_clr         = regs[TST_IDX][10];

  AST_RDATA_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[31:16] == '0); // R3
  AST_STATUS_VIEW: assert property (@(posedge clk) disable iff (rst)
    stat_hit |-> (bus_rdata[7:0] == stat_byte)); // R4
endmodule

// File: tb/test_ctl_bank_top.sv
module test_ctl_bank_top;
  logic        clk = 0;
  logic        rst;
  logic [15:0] bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [7:0]  stat_byte;
  logic [3:0]  lane_on, lane_force_rx, lane_force_stop, lane_turn_off;
  logic [7:0]  tst_din;
  logic        tst_en, tst_clk, tst_clr;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] model [6];
  bit done = 0;

  always #4 clk = ~clk;

  ctl_bank_top i_ctl_bank_top (.*);

  function automatic logic [15:0] offs(input int i);
    case (i)
      0: return 16'h6224; 1: return 16'h6254; 2: return 16'h6258;
      3: return 16'h625c; 4: return 16'h6260; default: return 16'h6264;
    endcase
  endfunction

  function automatic int idx_of(input logic [15:0] a);
    for (int i = 0; i < 6; i++) if (offs(i) == a) return i;
    return -1;
  endfunction

  function automatic logic [15:0] apply(input logic [15:0] o, input logic [31:0] w);
    logic [15:0] r;
    for (int b = 0; b < 16; b++) r[b] = w[b+16] ? w[b] : o[b];
    return r;
  endfunction

  function automatic logic [31:0] exp_read(input logic [15:0] a);
    int k = idx_of(a);
    if (k >= 0) return {16'h0, model[k]};
    if (a == 16'he2a4) return {24'h0, stat_byte};
    return 32'h0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [31:0] w);
    int k = idx_of(a);
    @(negedge clk);
    bus_addr = a; bus_wr = 1; bus_wdata = w;
    @(negedge clk);
    bus_wr = 0;
    if (k >= 0) model[k] = apply(model[k], w);
  endtask

  task automatic rd(input string req, input logic [15:0] a);
    bus_addr = a; #1;
    chk(req, bus_rdata, exp_read(a));
  endtask

  task automatic check_pins();
    #1;
    chk("R7", {16'h0, lane_turn_off, lane_force_stop, lane_force_rx, lane_on}, {16'h0, model[1]});
    chk("R8", {21'h0, tst_clr, tst_clk, tst_en, tst_din}, {21'h0, model[5][10:0]});
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < 6; i++) rd(req, offs(i));
    check_pins();
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7031));
    rst = 1; bus_addr = 0; bus_wr = 0; bus_wdata = 0; stat_byte = 8'h5a;
    for (int i = 0; i < 6; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    // R6: set a few bits, then reset, expect zeros
    rst = 0;
    do_write(16'h6254, 32'hffff_a5a5);
    rst = 1; @(negedge clk); rst = 0;
    for (int i = 0; i < 6; i++) model[i] = 0;
    sweep("R6");
    // R1/R7: full-mask write to lane register
    do_write(16'h6254, 32'hffff_1234);
    rd("R1", 16'h6254); check_pins();
    // R2: partial mask keeps unmasked bits
    do_write(16'h6254, 32'h00f0_ffff);
    rd("R2", 16'h6254); check_pins();
    // R8: test register strobes individually
    do_write(16'h6264, 32'h0200_0200);
    check_pins();
    do_write(16'h6264, 32'h05ff_04c3);
    rd("R8", 16'h6264); check_pins();
    // R5: status and unmapped writes change nothing
    do_write(16'he2a4, 32'hffff_ffff);
    do_write(16'h6228, 32'hffff_ffff);
    sweep("R5");
    // R4, R9: status and unmapped reads
    stat_byte = 8'hc3; rd("R4", 16'he2a4);
    rd("R9", 16'h0000); rd("R9", 16'h6250);
    // R3: zero-mask write keeps all, upper read half zero
    do_write(16'h6224, 32'h0000_ffff);
    rd("R3", 16'h6224);
    // random traffic
    for (int n = 0; n < 400; n++) begin
      logic [15:0] a;
      int sel = $urandom_range(0, 9);
      if (sel < 7) a = offs(sel % 6);
      else if (sel == 7) a = 16'he2a4;
      else a = 16'($urandom);
      stat_byte = 8'($urandom);
      do_write(a, $urandom);
      rd("R10", a);
      if (n % 25 == 0) sweep("R10");
    end
    sweep("R10");
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule